// File: doc/BRIEF.md
# Viewport-Indexed Address Translation Unit

This block translates addresses through a set of programmable windows. There are two window banks, one for inbound traffic and one for outbound traffic. Each bank holds `NUM_WIN` windows. Software reaches every window through one shared group of registers. A selector register at offset 0x900 decides which window that group currently addresses: it gives the direction and the window number.

Each window has a 64-bit start address, a 32-bit end address, a 64-bit destination, a type word and a control word whose top bit enables the window. Writes to these registers go into a staged copy. The decode logic does not see them until software writes the control word, and that write commits the whole window at once.

For each lookup, the block compares the address with every enabled window of the requested direction. The lowest-numbered window that matches wins. A memory-type window produces a translated 64-bit address. A configuration-type window produces a bus number, a device/function number and a register offset. When no window matches, the block flags a miss.

Top module: `atu_viewport_xlate`

## Requirements
- R1: The selector register at offset 0x900 stores the full 32-bit value written to it and reads it back. Bits 3:0 give the window number. Bit 31 gives the direction: 1 is inbound, 0 is outbound.
- R2: The per-window registers sit at these offsets: 0x904 type, 0x908 control, 0x90C start low, 0x910 start high, 0x914 end, 0x918 destination low, 0x91C destination high. Each read returns the stored value of the window that the selector currently addresses.
- R3: After reset, the selector and every type word are 0. Every start and destination is 0, and every end is 0xFFFFFFFF. The inbound window 0 control word reads 0x80000000 and that window is active, so inbound traffic passes through unchanged. Every other control word reads 0.
- R4: Writes to the type, start, end or destination registers do not change the active decode. A write to the control word copies the staged values into the decode, with control bit 31 as the enable.
- R5: A window matches only if it is enabled, its direction equals the lookup direction, and start <= address <= E. E is formed from bits 63:32 of the start and the 32-bit end in bits 31:0.
- R6: For a type word of 0 (memory), the translated address is destination + (address − start).
- R7: For a type word other than 0 (configuration), the block outputs these fields:
  - bus: destination bits 31:24
  - device/function: destination bits 23:16
  - offset: (address − start) modulo 2^`CFG_OFF_W`
- R8: When several windows match, the lowest-numbered one wins, and the block reports its number.
- R9: On a miss, the hit flag is 0 and the translated address is all ones.
- R10: If the selector names a window number of `NUM_WIN` or more, per-window registers read as 0 and writes to them are ignored.
- R11: The result appears with `res_valid` high exactly one clock after a lookup is presented with `lk_valid`. `res_valid` is low in every cycle that does not follow a lookup.
- R12: Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_off) |
| lk_valid | input | 1 | Lookup request |
| lk_inbound | input | 1 | Lookup direction, 1 is inbound |
| lk_addr | input | 64 | Lookup address |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | A window matched |
| res_cfg | output | 1 | The matching window is configuration type |
| res_win | output | WIN_W | Number of the matching window |
| res_addr | output | 64 | Translated address, all ones on a miss |
| res_bus | output | 8 | Configuration bus number |
| res_devfn | output | 8 | Configuration device/function |
| res_off | output | CFG_OFF_W | Configuration register offset |

## Verification
Faulty staged or active state shows up in different places. A bad staged value appears at `reg_rdata` in the same cycle the register is addressed. A bad active value appears only through lookups, one clock later, as a wrong hit, a wrong window number or a wrong address. Because of this, the bench programs a window and probes it before committing it and again after. It also compares readback and lookups at the range edges, where the two copies diverge. Misdecoding the window number or direction shows up as a write landing in the wrong window, which the bench detects by reading the neighbouring window and by issuing lookups in the other direction.

// File: rtl/atu_pkg.sv
package atu_pkg;
   localparam int REG_OFF_W = 12;

   localparam logic [REG_OFF_W-1:0] OFF_VIEW   = 12'h900;
   localparam logic [REG_OFF_W-1:0] OFF_TYPE   = 12'h904;
   localparam logic [REG_OFF_W-1:0] OFF_CTRL   = 12'h908;
   localparam logic [REG_OFF_W-1:0] OFF_BASE_L = 12'h90C;
   localparam logic [REG_OFF_W-1:0] OFF_BASE_H = 12'h910;
   localparam logic [REG_OFF_W-1:0] OFF_LIMIT  = 12'h914;
   localparam logic [REG_OFF_W-1:0] OFF_TGT_L  = 12'h918;
   localparam logic [REG_OFF_W-1:0] OFF_TGT_H  = 12'h91C;

   localparam int EN_BIT = 31;

   typedef struct packed {
      logic [63:0] base;
      logic [31:0] limit;
      logic [63:0] target;
      logic [31:0] typ;
      logic [31:0] ctrl;
   } win_regs_t;
endpackage

// File: rtl/atu_window.sv
module atu_window
   import atu_pkg::*;
#(
   parameter int CFG_OFF_W = 12,
   parameter bit OPEN_AT_RESET = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sel,
   input  logic                 we,
   input  logic [REG_OFF_W-1:0] reg_off,
   input  logic [31:0]          wdata,
   input  logic [63:0]          lk_addr,
   output win_regs_t            staged,
   output logic                 hit,
   output logic                 is_cfg,
   output logic [63:0]          xaddr,
   output logic [7:0]           bus,
   output logic [7:0]           devfn,
   output logic [CFG_OFF_W-1:0] off
);
   win_regs_t rst_val;
   win_regs_t active;
   logic [63:0] upper;
   logic [63:0] delta;
   logic        commit;

   generate
      if (OPEN_AT_RESET) begin : g_open
         assign rst_val = '{base: '0, limit: '1, target: '0, typ: '0,
                            ctrl: 32'h8000_0000};
      end else begin : g_closed
         assign rst_val = '{base: '0, limit: '1, target: '0, typ: '0,
                            ctrl: '0};
      end
   endgenerate

   assign commit = sel && we && (reg_off == OFF_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= rst_val;
         active <= rst_val;
      end else begin
         if (sel && we) begin
            case (reg_off)
               OFF_TYPE:   staged.typ           <= wdata;
               OFF_CTRL:   staged.ctrl          <= wdata;
               OFF_BASE_L: staged.base[31:0]    <= wdata;
               OFF_BASE_H: staged.base[63:32]   <= wdata;
               OFF_LIMIT:  staged.limit         <= wdata;
               OFF_TGT_L:  staged.target[31:0]  <= wdata;
               OFF_TGT_H:  staged.target[63:32] <= wdata;
               default: ;
            endcase
         end
         if (commit) begin
            active      <= staged;
            active.ctrl <= wdata;
         end
      end
   end

   assign upper  = {active.base[63:32], active.limit};
   assign delta  = lk_addr - active.base;
   assign hit    = active.ctrl[EN_BIT] && (lk_addr >= active.base) && (lk_addr <= upper);
   assign is_cfg = (active.typ != '0);
   assign xaddr  = active.target + delta;
   assign bus    = active.target[31:24];
   assign devfn  = active.target[23:16];
   assign off    = delta[CFG_OFF_W-1:0];

   p_commit_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active))
      else $error("active decode changed without a control write");

   p_unsel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(staged))
      else $error("staged registers changed while not selected");
endmodule

// File: rtl/atu_pick.sv
module atu_pick #(
   parameter int NUM_WIN   = 4,
   parameter int CFG_OFF_W = 12,
   localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WIN-1:0]   hits,
   input  logic [NUM_WIN-1:0]   cfgs,
   input  logic [63:0]          xaddr [NUM_WIN],
   input  logic [7:0]           bus   [NUM_WIN],
   input  logic [7:0]           devfn [NUM_WIN],
   input  logic [CFG_OFF_W-1:0] off   [NUM_WIN],
   output logic                 any,
   output logic [WIN_W-1:0]     idx,
   output logic                 o_cfg,
   output logic [63:0]          o_addr,
   output logic [7:0]           o_bus,
   output logic [7:0]           o_devfn,
   output logic [CFG_OFF_W-1:0] o_off
);
   always_comb begin
      any     = 1'b0;
      idx     = '0;
      o_cfg   = 1'b0;
      o_addr  = '1;
      o_bus   = '0;
      o_devfn = '0;
      o_off   = '0;
      for (int w = NUM_WIN - 1; w >= 0; w--) begin
         if (hits[w]) begin
            any     = 1'b1;
            idx     = WIN_W'(w);
            o_cfg   = cfgs[w];
            o_addr  = xaddr[w];
            o_bus   = bus[w];
            o_devfn = devfn[w];
            o_off   = off[w];
         end
      end
   end

   p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> (hits[idx] && ((hits & ((NUM_WIN'(1) << idx) - NUM_WIN'(1))) == '0)))
      else $error("selected window is not the lowest match");

   p_any_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any == (hits != '0))
      else $error("match flag disagrees with window matches");
endmodule

// File: rtl/atu_viewport_xlate.sv
module atu_viewport_xlate
   import atu_pkg::*;
#(
   parameter int NUM_WIN   = 4,
   parameter int CFG_OFF_W = 12,
   localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [11:0]          reg_off,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 lk_valid,
   input  logic                 lk_inbound,
   input  logic [63:0]          lk_addr,
   output logic                 res_valid,
   output logic                 res_hit,
   output logic                 res_cfg,
   output logic [WIN_W-1:0]     res_win,
   output logic [63:0]          res_addr,
   output logic [7:0]           res_bus,
   output logic [7:0]           res_devfn,
   output logic [CFG_OFF_W-1:0] res_off
);
   if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_num
      $error("NUM_WIN must lie in 1..16");
   end
   if (CFG_OFF_W < 8 || CFG_OFF_W > 16) begin : g_bad_off
      $error("CFG_OFF_W must lie in 8..16");
   end

   logic [31:0] vp;
   logic [3:0]  vp_idx;
   logic        vp_in;
   logic        vp_ok;

   assign vp_idx = vp[3:0];
   assign vp_in  = vp[31];
   assign vp_ok  = ({1'b0, vp_idx} < 5'(NUM_WIN));

   always_ff @(posedge clk) begin
      if (!rst_n)                              vp <= '0;
      else if (reg_we && reg_off == OFF_VIEW)  vp <= reg_wdata;
   end

   win_regs_t            stg    [2][NUM_WIN];
   logic [NUM_WIN-1:0]   hit_d  [2];
   logic [NUM_WIN-1:0]   cfg_d  [2];
   logic [63:0]          xa_d   [2][NUM_WIN];
   logic [7:0]           bus_d  [2][NUM_WIN];
   logic [7:0]           dev_d  [2][NUM_WIN];
   logic [CFG_OFF_W-1:0] off_d  [2][NUM_WIN];

   for (genvar d = 0; d < 2; d++) begin : g_dir
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         logic sel;
         assign sel = vp_ok && (vp_in == d[0]) && (vp_idx == 4'(w));
         atu_window #(
            .CFG_OFF_W     (CFG_OFF_W),
            .OPEN_AT_RESET (d == 1 && w == 0)
         ) i_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel),
            .we      (reg_we),
            .reg_off (reg_off),
            .wdata   (reg_wdata),
            .lk_addr (lk_addr),
            .staged  (stg[d][w]),
            .hit     (hit_d[d][w]),
            .is_cfg  (cfg_d[d][w]),
            .xaddr   (xa_d[d][w]),
            .bus     (bus_d[d][w]),
            .devfn   (dev_d[d][w]),
            .off     (off_d[d][w])
         );
      end
   end

   win_regs_t rd_win;
   always_comb begin
      rd_win = '0;
      for (int d = 0; d < 2; d++)
         for (int w = 0; w < NUM_WIN; w++)
            if (vp_ok && (vp_in == d[0]) && (vp_idx == 4'(w))) rd_win = stg[d][w];
   end

   always_comb begin
      case (reg_off)
         OFF_VIEW:   reg_rdata = vp;
         OFF_TYPE:   reg_rdata = rd_win.typ;
         OFF_CTRL:   reg_rdata = rd_win.ctrl;
         OFF_BASE_L: reg_rdata = rd_win.base[31:0];
         OFF_BASE_H: reg_rdata = rd_win.base[63:32];
         OFF_LIMIT:  reg_rdata = rd_win.limit;
         OFF_TGT_L:  reg_rdata = rd_win.target[31:0];
         OFF_TGT_H:  reg_rdata = rd_win.target[63:32];
         default:    reg_rdata = '0;
      endcase
   end

   logic [NUM_WIN-1:0]   s_hit, s_cfg;
   logic [63:0]          s_xa  [NUM_WIN];
   logic [7:0]           s_bus [NUM_WIN];
   logic [7:0]           s_dev [NUM_WIN];
   logic [CFG_OFF_W-1:0] s_off [NUM_WIN];

   always_comb begin
      s_hit = lk_inbound ? hit_d[1] : hit_d[0];
      s_cfg = lk_inbound ? cfg_d[1] : cfg_d[0];
      for (int w = 0; w < NUM_WIN; w++) begin
         s_xa[w]  = lk_inbound ? xa_d[1][w]  : xa_d[0][w];
         s_bus[w] = lk_inbound ? bus_d[1][w] : bus_d[0][w];
         s_dev[w] = lk_inbound ? dev_d[1][w] : dev_d[0][w];
         s_off[w] = lk_inbound ? off_d[1][w] : off_d[0][w];
      end
   end

   logic                 p_any, p_cfg;
   logic [WIN_W-1:0]     p_idx;
   logic [63:0]          p_addr;
   logic [7:0]           p_bus, p_dev;
   logic [CFG_OFF_W-1:0] p_off;

   atu_pick #(.NUM_WIN(NUM_WIN), .CFG_OFF_W(CFG_OFF_W)) i_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .hits    (s_hit),
      .cfgs    (s_cfg),
      .xaddr   (s_xa),
      .bus     (s_bus),
      .devfn   (s_dev),
      .off     (s_off),
      .any     (p_any),
      .idx     (p_idx),
      .o_cfg   (p_cfg),
      .o_addr  (p_addr),
      .o_bus   (p_bus),
      .o_devfn (p_dev),
      .o_off   (p_off)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_cfg   <= 1'b0;
         res_win   <= '0;
         res_addr  <= '0;
         res_bus   <= '0;
         res_devfn <= '0;
         res_off   <= '0;
      end else begin
         res_valid <= lk_valid;
         if (lk_valid) begin
            res_hit   <= p_any;
            res_cfg   <= p_any && p_cfg;
            res_win   <= p_idx;
            res_addr  <= p_any ? p_addr : '1;
            res_bus   <= p_bus;
            res_devfn <= p_dev;
            res_off   <= p_off;
         end
      end
   end

   p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid)
      else $error("result missing one cycle after lookup");

   p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid)
      else $error("result valid without lookup");

   p_view_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_off == OFF_VIEW) |=> $stable(vp))
      else $error("selector changed without a write");
endmodule

// File: tb/test_atu_viewport_xlate.sv
module test_atu_viewport_xlate;
   localparam int CLK_PERIOD = 10;

   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_LK = 2'd2;

   typedef struct packed {
      logic [1:0]  kind;
      logic        dir;
      logic [11:0] off;
      logic [63:0] val;
      logic        e_hit;
      logic        e_cfg;
      logic [1:0]  e_win;
      logic [63:0] e_addr;
      logic [7:0]  e_bus;
      logic [7:0]  e_dev;
      logic [11:0] e_off;
      logic [23:0] tag;
   } vec_t;

   function automatic vec_t vw(logic [11:0] o, logic [31:0] d);
      vec_t v;
      v = '0; v.kind = K_WR; v.off = o; v.val = {32'h0, d};
      return v;
   endfunction

   function automatic vec_t vr(logic [11:0] o, logic [31:0] e, logic [23:0] t);
      vec_t v;
      v = '0; v.kind = K_RD; v.off = o; v.val = {32'h0, e}; v.tag = t;
      return v;
   endfunction

   function automatic vec_t vl(logic dir, logic [63:0] a, logic h, logic c, logic [1:0] w,
                               logic [63:0] ea, logic [7:0] b, logic [7:0] df,
                               logic [11:0] eo, logic [23:0] t);
      vec_t v;
      v = '0; v.kind = K_LK; v.dir = dir; v.val = a; v.e_hit = h; v.e_cfg = c;
      v.e_win = w; v.e_addr = ea; v.e_bus = b; v.e_dev = df; v.e_off = eo; v.tag = t;
      return v;
   endfunction

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 51;
   localparam vec_t VEC [NV] = '{
      vw(12'h900, 32'h1), vw(12'h90C, 32'h1000_0000), vw(12'h910, 32'h0),
      vw(12'h914, 32'h1000_FFFF), vw(12'h918, 32'h8000_0000), vw(12'h91C, 32'h2),
      vl(0, 64'h1000_0010, 0, 0, 0, ONES, 0, 0, 0, "R4"),
      vw(12'h908, 32'h8000_0000),
      vl(0, 64'h1000_0010, 1, 0, 1, 64'h2_8000_0010, 0, 0, 0, "R6"),
      vl(0, 64'h1001_0000, 0, 0, 0, ONES, 0, 0, 0, "R5"),
      vl(0, 64'h1000_FFFF, 1, 0, 1, 64'h2_8000_FFFF, 0, 0, 0, "R5"),
      vl(0, 64'h0FFF_FFFF, 0, 0, 0, ONES, 0, 0, 0, "R5"),
      vr(12'h918, 32'h8000_0000, "R2"), vr(12'h91C, 32'h2, "R2"),
      vw(12'h900, 32'h0), vw(12'h90C, 32'h1000_0000), vw(12'h914, 32'h1000_00FF),
      vw(12'h904, 32'h1), vw(12'h918, 32'h0528_0000), vw(12'h908, 32'h8000_0000),
      vl(0, 64'h1000_0010, 1, 1, 0, 0, 8'h05, 8'h28, 12'h010, "R7"),
      vl(0, 64'h1000_0200, 1, 0, 1, 64'h2_8000_0200, 0, 0, 0, "R8"),
      vw(12'h914, 32'h1000_FFFF),
      vl(0, 64'h1000_1234, 1, 0, 1, 64'h2_8000_1234, 0, 0, 0, "R4"),
      vw(12'h908, 32'h8000_0000),
      vl(0, 64'h1000_1234, 1, 1, 0, 0, 8'h05, 8'h28, 12'h234, "R7"),
      vr(12'h904, 32'h1, "R2"),
      vw(12'h900, 32'h5), vw(12'h90C, 32'hDEAD), vw(12'h908, 32'h0),
      vr(12'h90C, 32'h0, "R10"), vr(12'h900, 32'h5, "R1"),
      vw(12'h900, 32'h1),
      vr(12'h90C, 32'h1000_0000, "R10"), vr(12'h908, 32'h8000_0000, "R10"),
      vw(12'h908, 32'h0), vr(12'h908, 32'h0, "R4"),
      vw(12'h900, 32'h0), vw(12'h908, 32'h0),
      vl(0, 64'h1000_0200, 0, 0, 0, ONES, 0, 0, 0, "R9"),
      vr(12'h700, 32'h0, "R12"),
      vw(12'h900, 32'h8000_0002), vw(12'h90C, 32'h0), vw(12'h910, 32'h1),
      vw(12'h914, 32'h0000_0FFF), vw(12'h918, 32'h4000), vw(12'h908, 32'h8000_0000),
      vl(1, 64'h1_0000_0800, 1, 0, 2, 64'h4800, 0, 0, 0, "R5"),
      vl(1, 64'h0000_0800, 1, 0, 0, 64'h0800, 0, 0, 0, "R3"),
      vr(12'h900, 32'h8000_0002, "R1"),
      vl(0, 64'h1_0000_0800, 0, 0, 0, ONES, 0, 0, 0, "R5")
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_off = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic        lk_inbound = 1'b0;
   logic [63:0] lk_addr = '0;
   logic        res_valid, res_hit, res_cfg;
   logic [1:0]  res_win;
   logic [63:0] res_addr;
   logic [7:0]  res_bus, res_devfn;
   logic [11:0] res_off;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   atu_viewport_xlate i_atu_viewport_xlate (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
      .lk_inbound(lk_inbound), .lk_addr(lk_addr), .res_valid(res_valid),
      .res_hit(res_hit), .res_cfg(res_cfg), .res_win(res_win), .res_addr(res_addr),
      .res_bus(res_bus), .res_devfn(res_devfn), .res_off(res_off)
   );

   task automatic chk(input logic [23:0] tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic [11:0] o, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_off = o; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic do_rd(input logic [11:0] o, input logic [31:0] e, input logic [23:0] t);
      @(negedge clk);
      reg_off = o;
      #1;
      chk(t, "read", {32'h0, reg_rdata}, {32'h0, e});
   endtask

   task automatic do_lk(input vec_t v);
      @(negedge clk);
      lk_valid = 1'b1; lk_inbound = v.dir; lk_addr = v.val;
      @(negedge clk);
      lk_valid = 1'b0;
      chk(v.tag, "valid", 64'(res_valid), 64'h1);
      chk(v.tag, "hit", 64'(res_hit), 64'(v.e_hit));
      if (!v.e_hit) chk(v.tag, "miss addr", res_addr, ONES);
      else begin
         chk(v.tag, "win", 64'(res_win), 64'(v.e_win));
         chk(v.tag, "cfg", 64'(res_cfg), 64'(v.e_cfg));
         if (v.e_cfg) begin
            chk(v.tag, "bus", 64'(res_bus), 64'(v.e_bus));
            chk(v.tag, "devfn", 64'(res_devfn), 64'(v.e_dev));
            chk(v.tag, "off", 64'(res_off), 64'(v.e_off));
         end else chk(v.tag, "addr", res_addr, v.e_addr);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R3: reset state through readback and default pass-through
      do_rd(12'h900, 32'h0, "R3");
      do_rd(12'h908, 32'h0, "R3");
      do_rd(12'h914, 32'hFFFF_FFFF, "R3");
      do_rd(12'h90C, 32'h0, "R3");
      do_rd(12'h904, 32'h0, "R3");
      do_wr(12'h900, 32'h8000_0000);
      do_rd(12'h908, 32'h8000_0000, "R3");
      do_lk(vl(1, 64'hFFFF_FFFF, 1, 0, 0, 64'hFFFF_FFFF, 0, 0, 0, "R3"));
      do_lk(vl(0, 64'h0, 0, 0, 0, ONES, 0, 0, 0, "R3"));
      // R11: valid is a single-cycle pulse
      @(negedge clk);
      chk("R11", "idle valid", 64'(res_valid), 64'h0);

      for (int i = 0; i < NV; i++) begin
         case (VEC[i].kind)
            K_WR:    do_wr(VEC[i].off, VEC[i].val[31:0]);
            K_RD:    do_rd(VEC[i].off, VEC[i].val[31:0], VEC[i].tag);
            default: do_lk(VEC[i]);
         endcase
      end

      // R3: a second reset closes programmed windows again
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R11", "valid after reset", 64'(res_valid), 64'h0);
      do_lk(vl(1, 64'h1_0000_0800, 0, 0, 0, ONES, 0, 0, 0, "R3"));
      do_lk(vl(1, 64'h0000_0042, 1, 0, 0, 64'h42, 0, 0, 0, "R3"));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule